// File: doc/BRIEF.md
# Self-Triggered Segment Buffer Controller

This block keeps the digital bookkeeping for a sampler whose analog storage is split into a fixed number of short segments, each holding 32 sample bins. Every pulse on the self-trigger input claims the next free segment at the write pointer. At the same moment it records the value of a free-running coarse-time counter for that segment. No external accept signal is involved: the signal triggers itself.

A read sequencer runs at the same time as the writer. It drains filled segments oldest first. For each one it raises a data-available flag, waits for the downstream side to answer with a go pulse, and then issues one strobe per sample bin. Each strobe carries the segment index, the latched timestamp and the sample number, and strobes are spaced by a programmable divider. After the last strobe the segment is released.

When every segment is occupied, new triggers are discarded and counted in a saturating lost-trigger counter. The segment count must be a power of two (at least 2). The coarse counter runs on the block clock.

The read sequencer has five states:
- RD_IDLE: waits for the head segment to be valid.
- RD_OFFER: flags data available and waits for `rd_go`.
- RD_GAP: waits `div_cfg` cycles between strobes.
- RD_STROBE: emits one strobe.
- RD_DONE: releases the segment.

The sequencer moves between these states as follows:
- IDLE→OFFER when the head segment is valid.
- OFFER→STROBE when `rd_go` arrives and the divider is 0.
- OFFER→GAP when `rd_go` arrives and the divider is not 0.
- GAP→STROBE when the gap count runs out.
- STROBE→GAP or STROBE→STROBE (by the same divider test) while samples remain.
- STROBE→DONE after sample 31.
- DONE→IDLE.

Top module: `segbuf_ctrl`

## Requirements
- R1: A synchronous reset clears both pointers, all valid bits, the lost-trigger counter and the sequencer. After reset, `fill_level`=0, `lost_cnt`=0, and `data_avail` and `samp_stb` are both 0.
- R2: A trigger sampled at a clock edge while fewer than NSEG segments are occupied claims one segment. That segment's timestamp is the coarse count at that edge. The coarse count is 0 at the first edge after reset is released and rises by 1 at every edge, modulo 2^TS_W.
- R3: `data_avail` is high only while at least one segment is filled. Once raised, it stays high until an edge at which `rd_go` is sampled high.
- R4: Each drained segment produces exactly 32 `samp_stb` pulses. `samp_idx` counts 0 to 31 in order, and every strobe shows that segment's `seg_idx` and `seg_ts`. `data_avail` is low during strobes.
- R5: Consecutive strobes of one segment are `div_cfg`+1 clock cycles apart, so `div_cfg`=0 gives back-to-back strobes.
- R6: Segments are drained in write order, with `seg_idx` wrapping modulo NSEG. `fill_level` drops by one at the edge that ends the cycle after the 32nd strobe.
- R7: A trigger sampled while `fill_level`=NSEG is dropped and leaves occupancy unchanged. It adds one to `lost_cnt`, which holds at its all-ones value.
- R8: A trigger and a segment release at the same edge both take effect, so `fill_level` is unchanged. The full test uses the occupancy before that edge.
- R9: Triggers are accepted while a segment is being read out, with no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also drives the coarse counter |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Self-trigger; each cycle high is one trigger |
| rd_go | input | 1 | Downstream accepts the offered segment |
| div_cfg | input | DIV_W | Strobe spacing minus one, in cycles |
| data_avail | output | 1 | A filled segment is offered for readout |
| samp_stb | output | 1 | Sample read strobe |
| seg_idx | output | log2(NSEG) | Index of the segment being read |
| seg_ts | output | TS_W | Latched coarse timestamp of that segment |
| samp_idx | output | log2(SAMPLES) | Sample bin number for the strobe |
| fill_level | output | log2(NSEG)+1 | Number of occupied segments |
| lost_cnt | output | LOST_W | Saturating count of dropped triggers |

## Verification
The main function is exercised with four kinds of trigger pattern:
- A lone trigger, with both a zero and a non-zero divider. This separates correct strobe count and spacing from off-by-one gap errors.
- A burst that fills every slot while the reader is held off. This tells dropping from overwriting, and shows the counter saturating.
- A trigger timed onto the release cycle. This tells a simultaneous update apart from one that loses either side.
- Random trigger densities with random divider values and random `rd_go` latency, against a queue model. This separates FIFO order and correct timestamp capture from pointer-wrap mistakes.

A reset in the middle of a run confirms that pending segments are flushed.

// File: rtl/segbuf_pkg.sv
`timescale 1ns/1ps
package segbuf_pkg;
    typedef enum logic [2:0] {
        RD_IDLE,
        RD_OFFER,
        RD_GAP,
        RD_STROBE,
        RD_DONE
    } rd_state_t;
endpackage

// File: rtl/segbuf_tstamp.sv
`timescale 1ns/1ps
// Free-running coarse time counter
module segbuf_tstamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end
endmodule

// File: rtl/segbuf_store.sv
`timescale 1ns/1ps
// Write/read pointers, per-segment valid bits and timestamps, lost counter
module segbuf_store #(
    parameter int NSEG   = 8,
    parameter int TS_W   = 16,
    parameter int LOST_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_req,
    input  logic                      rd_done,
    input  logic [TS_W-1:0]           ts_in,
    output logic [$clog2(NSEG)-1:0]   rd_idx,
    output logic [TS_W-1:0]           rd_ts,
    output logic                      head_valid,
    output logic [$clog2(NSEG):0]     fill,
    output logic [LOST_W-1:0]         lost
);
    localparam int PW = $clog2(NSEG);
    localparam logic [PW:0] FULL_LVL = (PW+1)'(NSEG);

    logic [PW:0]      wr_ptr, rd_ptr;
    logic [NSEG-1:0]  seg_valid;
    logic [TS_W-1:0]  seg_ts [NSEG];
    logic             is_full, wr_fire;
    logic [PW-1:0]    wr_idx;

    assign fill    = wr_ptr - rd_ptr;
    assign is_full = (fill == FULL_LVL);
    assign wr_fire = wr_req && !is_full;
    assign wr_idx  = wr_ptr[PW-1:0];
    assign rd_idx  = rd_ptr[PW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lost   <= '0;
        end else begin
            if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
            if (rd_done) rd_ptr <= rd_ptr + 1'b1;
            if (wr_req && is_full && lost != '1) lost <= lost + 1'b1;
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                seg_valid[g] <= 1'b0;
            end else if (wr_fire && wr_idx == PW'(g)) begin
                seg_valid[g] <= 1'b1;
            end else if (rd_done && rd_idx == PW'(g)) begin
                seg_valid[g] <= 1'b0;
            end
        end
        always_ff @(posedge clk) begin
            if (wr_fire && wr_idx == PW'(g)) seg_ts[g] <= ts_in;
        end
    end

    assign head_valid = seg_valid[rd_idx];
    assign rd_ts      = seg_ts[rd_idx];
endmodule

// File: rtl/segbuf_rdseq.sv
`timescale 1ns/1ps
// Readout sequencer: offer, then one strobe per sample bin
module segbuf_rdseq
    import segbuf_pkg::*;
#(
    parameter int SAMPLES = 32,
    parameter int DIV_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       head_valid,
    input  logic                       rd_go,
    input  logic [DIV_W-1:0]           div_cfg,
    output logic                       data_avail,
    output logic                       samp_stb,
    output logic [$clog2(SAMPLES)-1:0] samp_idx,
    output logic                       rd_done
);
    localparam int SW = $clog2(SAMPLES);
    localparam logic [SW-1:0] LAST = SW'(SAMPLES - 1);

    rd_state_t        state, nxt;
    logic [SW-1:0]    samp;
    logic [DIV_W-1:0] gcnt;
    logic             no_gap;

    assign no_gap = (div_cfg == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:   if (head_valid) nxt = RD_OFFER;
            RD_OFFER:  if (rd_go) nxt = no_gap ? RD_STROBE : RD_GAP;
            RD_GAP:    if (gcnt == DIV_W'(1)) nxt = RD_STROBE;
            RD_STROBE: begin
                if (samp == LAST) nxt = RD_DONE;
                else              nxt = no_gap ? RD_STROBE : RD_GAP;
            end
            RD_DONE:   nxt = RD_IDLE;
            default:   nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
            samp  <= '0;
            gcnt  <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                RD_OFFER: if (rd_go) begin
                    samp <= '0;
                    gcnt <= div_cfg;
                end
                RD_GAP:   gcnt <= gcnt - 1'b1;
                RD_STROBE: if (samp != LAST) begin
                    samp <= samp + 1'b1;
                    gcnt <= div_cfg;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        data_avail = (state == RD_OFFER);
        samp_stb   = (state == RD_STROBE);
        rd_done    = (state == RD_DONE);
        samp_idx   = samp;
    end
endmodule

// File: rtl/segbuf_ctrl.sv
`timescale 1ns/1ps
module segbuf_ctrl #(
    parameter int NSEG    = 8,
    parameter int SAMPLES = 32,
    parameter int TS_W    = 16,
    parameter int LOST_W  = 8,
    parameter int DIV_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       trig_in,
    input  logic                       rd_go,
    input  logic [DIV_W-1:0]           div_cfg,
    output logic                       data_avail,
    output logic                       samp_stb,
    output logic [$clog2(NSEG)-1:0]    seg_idx,
    output logic [TS_W-1:0]            seg_ts,
    output logic [$clog2(SAMPLES)-1:0] samp_idx,
    output logic [$clog2(NSEG):0]      fill_level,
    output logic [LOST_W-1:0]          lost_cnt
);
    logic [TS_W-1:0] now;
    logic            head_valid, rd_done;

    segbuf_tstamp #(.TS_W(TS_W)) u_tstamp (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    segbuf_store #(.NSEG(NSEG), .TS_W(TS_W), .LOST_W(LOST_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (trig_in),
        .rd_done    (rd_done),
        .ts_in      (now),
        .rd_idx     (seg_idx),
        .rd_ts      (seg_ts),
        .head_valid (head_valid),
        .fill       (fill_level),
        .lost       (lost_cnt)
    );

    segbuf_rdseq #(.SAMPLES(SAMPLES), .DIV_W(DIV_W)) u_rdseq (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid),
        .rd_go      (rd_go),
        .div_cfg    (div_cfg),
        .data_avail (data_avail),
        .samp_stb   (samp_stb),
        .samp_idx   (samp_idx),
        .rd_done    (rd_done)
    );
endmodule

// File: rtl/segbuf_ctrl_chk.sv
`timescale 1ns/1ps
module segbuf_ctrl_chk #(
    parameter int NSEG    = 8,
    parameter int SAMPLES = 32,
    parameter int TS_W    = 16,
    parameter int LOST_W  = 8,
    parameter int DIV_W   = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       trig_in,
    input logic                       rd_go,
    input logic                       data_avail,
    input logic                       samp_stb,
    input logic [$clog2(SAMPLES)-1:0] samp_idx,
    input logic [$clog2(NSEG):0]      fill_level,
    input logic [LOST_W-1:0]          lost_cnt
);
    localparam int PW = $clog2(NSEG);
    localparam logic [PW:0] FULL_LVL = (PW+1)'(NSEG);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (fill_level == '0 && lost_cnt == '0 && !samp_stb && !data_avail));

    // R2
    accept_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_in && fill_level < FULL_LVL) |=> fill_level >= $past(fill_level));

    // R3
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_avail && !rd_go) |=> data_avail);

    // R4
    stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        samp_stb |-> (!data_avail && fill_level != '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill_level <= FULL_LVL);

    // R6
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fill_level) <= fill_level + 1'b1);

    // R7
    lost_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_in && fill_level == FULL_LVL && lost_cnt != '1)
            |=> lost_cnt == $past(lost_cnt) + 1'b1);

    // R7
    lost_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !trig_in |=> $stable(lost_cnt));
endmodule

bind segbuf_ctrl segbuf_ctrl_chk #(
    .NSEG(NSEG), .SAMPLES(SAMPLES), .TS_W(TS_W), .LOST_W(LOST_W), .DIV_W(DIV_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_in    (trig_in),
    .rd_go      (rd_go),
    .data_avail (data_avail),
    .samp_stb   (samp_stb),
    .samp_idx   (samp_idx),
    .fill_level (fill_level),
    .lost_cnt   (lost_cnt)
);

// File: tb/segbuf_ctrl_bench.sv
`timescale 1ns/1ps
module segbuf_ctrl_bench;
    localparam int NSEG = 8, SAMPLES = 32, TS_W = 16, LOST_W = 4, DIV_W = 4;
    localparam int PW = $clog2(NSEG), SW = $clog2(SAMPLES);
    localparam int LOST_MAX = (1 << LOST_W) - 1;

    logic clk = 1'b0, rst = 1'b1, trig_in = 1'b0, rd_go = 1'b0;
    logic [DIV_W-1:0]  div_cfg = '0;
    logic data_avail, samp_stb;
    logic [PW-1:0]     seg_idx;
    logic [TS_W-1:0]   seg_ts;
    logic [SW-1:0]     samp_idx;
    logic [PW:0]       fill_level;
    logic [LOST_W-1:0] lost_cnt;

    always #5 clk = ~clk;

    segbuf_ctrl #(.NSEG(NSEG), .SAMPLES(SAMPLES), .TS_W(TS_W), .LOST_W(LOST_W), .DIV_W(DIV_W))
    u_segbuf_ctrl (
        .clk(clk), .rst(rst), .trig_in(trig_in), .rd_go(rd_go), .div_cfg(div_cfg),
        .data_avail(data_avail), .samp_stb(samp_stb), .seg_idx(seg_idx), .seg_ts(seg_ts),
        .samp_idx(samp_idx), .fill_level(fill_level), .lost_cnt(lost_cnt)
    );

    int checks = 0, fails = 0;
    bit done_flag = 0;

    function automatic int sat_inc(int v);
        return (v >= LOST_MAX) ? LOST_MAX : v + 1;
    endfunction

    function automatic int exp_gap(int d);
        return d + 1;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference queue model, updated at each rising edge
    int mq[$];
    int m_rd = 0, m_lost = 0;
    bit pend = 0;
    int tb_ctr = 0;
    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); m_rd = 0; m_lost = 0; pend = 0; tb_ctr = 0;
        end else begin
            bit full_now;
            full_now = (mq.size() == NSEG);
            if (pend) begin
                if (mq.size() > 0) void'(mq.pop_front());
                m_rd++;
                pend = 0;
            end
            if (samp_stb && int'(samp_idx) == SAMPLES - 1) pend = 1;
            if (trig_in) begin
                if (full_now) m_lost = sat_inc(m_lost);
                else mq.push_back(tb_ctr % (1 << TS_W));
            end
            tb_ctr++;
        end
    end

    // Monitor at falling edges
    int cyc = 0, exp_samp = 0, last_stb = 0, stb_total = 0;
    bit mon_en = 0, go_en = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            exp_samp = 0; stb_total = 0;
        end else if (mon_en) begin
            check(int'(fill_level) == mq.size(), "R6 fill level", fill_level, mq.size());
            check(int'(lost_cnt) == m_lost, "R7 lost count", lost_cnt, m_lost);
            if (data_avail) check(mq.size() > 0, "R3 offer with filled segment", mq.size(), 1);
            if (samp_stb) begin
                stb_total++;
                check(int'(seg_idx) == m_rd % NSEG, "R6 segment order", seg_idx, m_rd % NSEG);
                if (mq.size() > 0)
                    check(int'(seg_ts) == mq[0], "R2 timestamp", seg_ts, mq[0]);
                check(int'(samp_idx) == exp_samp, "R4 sample number", samp_idx, exp_samp);
                if (exp_samp != 0)
                    check(cyc - last_stb == exp_gap(int'(div_cfg)), "R5 strobe spacing",
                          cyc - last_stb, exp_gap(int'(div_cfg)));
                last_stb = cyc;
                exp_samp = (exp_samp == SAMPLES - 1) ? 0 : exp_samp + 1;
            end
        end
        rd_go = go_en && data_avail && ($urandom % 2 == 0);
    end

    task automatic pulse_trig();
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic drain();
        trig_in = 1'b0;
        go_en = 1;
        while (fill_level != '0) @(negedge clk);
        @(negedge clk);
        check(stb_total == m_rd * SAMPLES, "R4 strobes per segment", stb_total, m_rd * SAMPLES);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int f0;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fill_level == '0, "R1 fill after reset", fill_level, 0);
        check(lost_cnt == '0, "R1 lost after reset", lost_cnt, 0);
        check(!data_avail && !samp_stb, "R1 outputs idle", {data_avail, samp_stb}, 0);
        rst = 1'b0;
        mon_en = 1;

        // Lone trigger, back-to-back strobes (R4, R5)
        div_cfg = '0; go_en = 1;
        repeat (4) @(negedge clk);
        pulse_trig();
        drain();

        // Short burst with a divider (R5, R6)
        div_cfg = 4'd3;
        pulse_trig(); pulse_trig(); pulse_trig();
        drain();

        // Fill while reader held off, then overflow and saturate (R7)
        go_en = 0;
        repeat (30) pulse_trig();
        check(int'(fill_level) == NSEG, "R7 full occupancy", fill_level, NSEG);
        check(int'(lost_cnt) == LOST_MAX, "R7 saturated lost count", lost_cnt, LOST_MAX);
        drain();

        // Trigger during readout (R9), then at the release cycle (R8)
        div_cfg = 4'd1;
        pulse_trig(); pulse_trig();
        go_en = 1;
        while (!samp_stb) @(negedge clk);
        f0 = int'(fill_level);
        pulse_trig();
        check(int'(fill_level) == f0 + 1, "R9 write during read", fill_level, f0 + 1);
        while (!(samp_stb && int'(samp_idx) == SAMPLES - 1)) @(negedge clk);
        @(negedge clk);
        f0 = int'(fill_level);
        pulse_trig();
        check(int'(fill_level) == f0, "R8 simultaneous trigger and release", fill_level, f0);
        drain();

        // Random phases
        for (int p = 0; p < 6; p++) begin
            int dens;
            div_cfg = DIV_W'($urandom % 5);
            dens = 2 + int'($urandom % 40);
            for (int c = 0; c < 2000; c++) begin
                trig_in = ($urandom % dens == 0);
                @(negedge clk);
            end
            drain();
        end

        // Reset with pending segments (R1)
        go_en = 0;
        repeat (5) pulse_trig();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(fill_level == '0, "R1 fill after mid-run reset", fill_level, 0);
        check(lost_cnt == '0, "R1 lost after mid-run reset", lost_cnt, 0);
        go_en = 1;
        pulse_trig();
        drain();

        finish_run();
    end
endmodule